// File: doc/BRIEF.md
# Eight-Input Prioritized Interrupt Controller

This block gathers eight interrupt request lines into a single interrupt output for a host processor. Each line is captured into a pending-request register, either on a rising edge (held until acknowledged) or as a level that follows the input. A mask register keeps chosen lines from reaching the output, and an in-service register records which levels the host is currently handling. The output is raised only when an unmasked pending request outranks every level that is in service, so that nested servicing works: a more urgent line can interrupt a less urgent handler, but never the reverse.

The host programs the block through a small register port with an active-low chip select, active-low read and write strobes, a 2-bit register address and separate 8-bit write and read data buses. An active-low acknowledge strobe makes the block return a vector byte for the winning level, move that level into service and drop its pending bit. A write to the command address ends the most urgent service in progress. Priority is fixed: line 0 is the most urgent and line 7 the least.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF (all lines masked), the trigger-mode register reads 0x00 (all edge), the vector base is 0, the pending and in-service registers read 0x00, and `irq_out` is low.
- R2: With a line's trigger-mode bit at 0 (edge), a 0-to-1 change of `req_in[i]` sets pending bit i at the next clock edge; the bit stays set after the input drops, until that level is acknowledged, and an input held high does not set it again.
- R3: With a line's trigger-mode bit at 1 (level), pending bit i takes the value `req_in[i]` had at the previous clock edge.
- R4: A line whose mask bit is 1 never causes `irq_out` and is never granted; its pending bit is still recorded.
- R5: On acknowledge, the granted level is the lowest-numbered unmasked pending level that outranks all in-service levels, and while `ack_n` is low `rdata` holds the vector {base[4:0], level[2:0]}, base in bits 7:3.
- R6: An acknowledge with a grant sets the granted in-service bit and, in edge mode, clears its pending bit at the same clock edge.
- R7: `irq_out` is high exactly when some unmasked pending level has a lower number than the lowest-numbered in-service level (any unmasked pending level when none is in service).
- R8: A write to address 3 (end of service; data ignored) clears the lowest-numbered set in-service bit.
- R9: Registers change only on a clock edge where `cs_n` and `wr_n` are both low; write address 0 loads the mask, 1 the trigger mode, 2 the vector base from `wdata[7:3]`. Read address 0 returns the mask, 1 the pending register, 2 the in-service register, 3 the trigger mode; with no read or acknowledge active `rdata` is 0x00.
- R10: An acknowledge with no eligible request returns {base, 3'b111} and changes neither the pending nor the in-service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Interrupt request lines, bit 0 most urgent |
| cs_n | input | 1 | Active-low register port select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Read data or acknowledge vector to host |
| ack_n | input | 1 | Active-low interrupt acknowledge strobe |
| irq_out | output | 1 | Interrupt request to host |

## Verification
A corrupted pending or in-service bit shows at the ports within the same cycle as a wrong `irq_out` level or, at the next acknowledge, a wrong level number in the vector byte, and it can be read back directly at addresses 1 and 2. A faulty priority chain shows as the wrong vector for a multi-bit request pattern, which is why every request pattern and every mask pattern is swept with an acknowledge after each. Nesting faults show one cycle after an end-of-service write, when the output must rise again for a lower level that was held back.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int NUM_LVL = 8;
    localparam int IDX_W   = $clog2(NUM_LVL);
    localparam int DATA_W  = 8;
    localparam int BASE_W  = DATA_W - IDX_W;

    typedef logic [NUM_LVL-1:0] lvl_vec_t;
    typedef logic [IDX_W-1:0]   lvl_idx_t;

    typedef enum logic [1:0] {
        SLOT_MASK = 2'd0,
        SLOT_MODE = 2'd1,
        SLOT_BASE = 2'd2,
        SLOT_CMD  = 2'd3
    } wr_slot_e;

    typedef enum logic [1:0] {
        VIEW_MASK = 2'd0,
        VIEW_PEND = 2'd1,
        VIEW_SERV = 2'd2,
        VIEW_MODE = 2'd3
    } rd_slot_e;

    typedef struct packed {
        logic     valid;
        lvl_vec_t onehot;
        lvl_idx_t idx;
    } grant_t;

    // isolate the lowest set bit (most urgent level)
    function automatic lvl_vec_t lowest_bit(input lvl_vec_t v);
        return v & (~v + lvl_vec_t'(1));
    endfunction

    function automatic lvl_idx_t bit_index(input lvl_vec_t oh);
        lvl_idx_t r;
        r = '0;
        for (int k = 0; k < NUM_LVL; k++)
            if (oh[k]) r = lvl_idx_t'(k);
        return r;
    endfunction

    // levels strictly more urgent than the most urgent in-service level;
    // an empty in-service set yields all ones
    function automatic lvl_vec_t outrank_mask(input lvl_vec_t serv);
        return lowest_bit(serv) - lvl_vec_t'(1);
    endfunction

endpackage

// File: rtl/irq_host_if.sv
module irq_host_if
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output lvl_vec_t          mask,
    output lvl_vec_t          trig_level,
    output logic [BASE_W-1:0] vec_base,
    output logic              eoi_stb,
    output logic              rd_en
);

    logic wr_en;
    assign wr_en   = !cs_n && !wr_n;
    assign rd_en   = !cs_n && !rd_n;
    assign eoi_stb = wr_en && (wr_slot_e'(addr) == SLOT_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask       <= '1;
            trig_level <= '0;
            vec_base   <= '0;
        end else if (wr_en) begin
            case (wr_slot_e'(addr))
                SLOT_MASK: mask       <= wdata;
                SLOT_MODE: trig_level <= wdata;
                SLOT_BASE: vec_base   <= wdata[DATA_W-1:IDX_W];
                default:   ;
            endcase
        end
    end

    // R9: no register moves without a selected write
    a_r9_no_write_unselected: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(mask) && $stable(trig_level) && $stable(vec_base)));

endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture
    import prio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t req_in,
    input  lvl_vec_t trig_level,
    input  lvl_vec_t clr,
    output lvl_vec_t pend
);

    lvl_vec_t prev;

    for (genvar i = 0; i < NUM_LVL; i++) begin : g_line
        logic rise;
        assign rise = req_in[i] && !prev[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                prev[i] <= 1'b0;
                pend[i] <= 1'b0;
            end else begin
                prev[i] <= req_in[i];
                if (trig_level[i])
                    pend[i] <= req_in[i];
                else if (rise)
                    pend[i] <= 1'b1;
                else if (clr[i])
                    pend[i] <= 1'b0;
            end
        end

        // R2: an edge-mode pending bit survives until it is granted
        a_r2_edge_hold: assert property (@(posedge clk) disable iff (rst)
            (!trig_level[i] && pend[i] && !clr[i]) |=> pend[i]);

        // R6: an edge-mode grant drops the pending bit
        a_r6_edge_clear: assert property (@(posedge clk) disable iff (rst)
            (!trig_level[i] && clr[i] && !rise) |=> !pend[i]);
    end

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import prio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t pend,
    input  lvl_vec_t mask,
    input  logic     ack,
    input  logic     eoi,
    output lvl_vec_t serv,
    output grant_t   grant,
    output logic     irq_out
);

    lvl_vec_t eligible;
    lvl_vec_t serv_nxt;

    assign eligible     = pend & ~mask & outrank_mask(serv);
    assign grant.valid  = |eligible;
    assign grant.onehot = lowest_bit(eligible);
    assign grant.idx    = bit_index(grant.onehot);
    assign irq_out      = grant.valid;

    always_comb begin
        serv_nxt = serv;
        if (eoi)
            serv_nxt = serv_nxt & ~lowest_bit(serv);
        if (ack && grant.valid)
            serv_nxt = serv_nxt | grant.onehot;
    end

    always_ff @(posedge clk) begin
        if (rst) serv <= '0;
        else     serv <= serv_nxt;
    end

    // R5: at most one level is granted
    always_comb begin
        a_r5_single_grant: assert ($onehot0(grant.onehot));
    end

    // R6: a grant lands in the in-service register
    a_r6_grant_in_service: assert property (@(posedge clk) disable iff (rst)
        (ack && grant.valid && !eoi) |=> ((serv & $past(grant.onehot)) == $past(grant.onehot)));

    // R8: end of service removes exactly one level
    a_r8_eoi_one_level: assert property (@(posedge clk) disable iff (rst)
        (eoi && !ack && serv != '0) |=> ($countones(serv) + 1 == $countones($past(serv))));

    // R10: an acknowledge without a grant leaves the in-service set alone
    a_r10_spurious_stable: assert property (@(posedge clk) disable iff (rst)
        (ack && !grant.valid && !eoi) |=> $stable(serv));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        req_in,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              ack_n,
    output logic              irq_out
);

    lvl_vec_t          mask, trig_level, pend, serv, clr;
    logic [BASE_W-1:0] vec_base;
    logic              eoi_stb, rd_en, ack;
    grant_t            grant;

    assign ack = !ack_n;
    assign clr = (ack && grant.valid) ? grant.onehot : '0;

    irq_host_if u_host (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .addr       (addr),
        .wdata      (wdata),
        .mask       (mask),
        .trig_level (trig_level),
        .vec_base   (vec_base),
        .eoi_stb    (eoi_stb),
        .rd_en      (rd_en)
    );

    irq_req_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .req_in     (req_in),
        .trig_level (trig_level),
        .clr        (clr),
        .pend       (pend)
    );

    irq_resolver u_res (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend),
        .mask    (mask),
        .ack     (ack),
        .eoi     (eoi_stb),
        .serv    (serv),
        .grant   (grant),
        .irq_out (irq_out)
    );

    always_comb begin
        rdata = '0;
        if (ack) begin
            rdata = grant.valid ? {vec_base, grant.idx} : {vec_base, {IDX_W{1'b1}}};
        end else if (rd_en) begin
            case (rd_slot_e'(addr))
                VIEW_MASK: rdata = mask;
                VIEW_PEND: rdata = pend;
                VIEW_SERV: rdata = serv;
                VIEW_MODE: rdata = trig_level;
                default:   rdata = '0;
            endcase
        end
    end

    // R4: the output never rises for masked-only requests
    a_r4_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ((pend & ~mask) != '0));

    // R7: with nothing pending the output stays low
    a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> !irq_out);

endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_in = 8'h00;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ack_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [7:0] BASE = 8'hA8;

    always #4 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst(rst), .req_in(req_in), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ack_n(ack_n), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = rdata;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic do_ack(output logic [7:0] v);
        @(negedge clk);
        ack_n = 1'b0;
        #1 v = rdata;
        @(negedge clk);
        ack_n = 1'b1;
    endtask

    task automatic set_req(input logic [7:0] r);
        @(negedge clk);
        req_in = r;
        @(negedge clk);
    endtask

    task automatic irq_chk(input string tag, input logic exp);
        @(negedge clk);
        #1 chk(tag, {7'd0, irq_out}, {7'd0, exp});
    endtask

    function automatic int low_idx(input logic [7:0] v);
        for (int k = 0; k < 8; k++) if (v[k]) return k;
        return 7;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d, v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(2'd0, d); chk("R1 mask", d, 8'hFF);
        rd(2'd1, d); chk("R1 pend", d, 8'h00);
        rd(2'd2, d); chk("R1 serv", d, 8'h00);
        rd(2'd3, d); chk("R1 mode", d, 8'h00);
        irq_chk("R1 irq", 1'b0);

        // R9 unselected write ignored, idle read bus zero
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; wdata = 8'h00;
        @(negedge clk);
        wr_n = 1'b1;
        rd(2'd0, d); chk("R9 write without select", d, 8'hFF);
        @(negedge clk); #1 chk("R9 idle rdata", rdata, 8'h00);

        wr(2'd2, BASE);
        wr(2'd0, 8'h00);
        rd(2'd0, d); chk("R9 mask write", d, 8'h00);

        // R2/R5/R6/R8 per-line edge sweep
        for (int i = 0; i < 8; i++) begin
            set_req(8'(1 << i));
            set_req(8'h00);
            rd(2'd1, d); chk("R2 edge held", d, 8'(1 << i));
            irq_chk("R7 single pending", 1'b1);
            do_ack(v); chk("R5 vector", v, BASE | 8'(i));
            rd(2'd2, d); chk("R6 serv set", d, 8'(1 << i));
            rd(2'd1, d); chk("R6 pend cleared", d, 8'h00);
            irq_chk("R7 served low", 1'b0);
            wr(2'd3, 8'h5A);
            rd(2'd2, d); chk("R8 eoi", d, 8'h00);
        end

        // R2 held input does not retrigger
        set_req(8'h08);
        do_ack(v); chk("R5 held vector", v, BASE | 8'd3);
        @(negedge clk);
        rd(2'd1, d); chk("R2 no retrigger", d, 8'h00);
        wr(2'd3, 8'h00);
        irq_chk("R2 no retrigger irq", 1'b0);
        set_req(8'h00);

        // R3/R5/R10 level mode, every request pattern
        wr(2'd1, 8'hFF);
        for (int p = 0; p < 256; p++) begin
            set_req(8'(p));
            rd(2'd1, d); chk("R3 level follows", d, 8'(p));
            irq_chk("R7 level irq", p != 0);
            do_ack(v);
            chk(p != 0 ? "R5 level vector" : "R10 spurious vector", v,
                BASE | 8'(low_idx(8'(p))));
            rd(2'd2, d);
            chk("R6 level serv", d, p != 0 ? 8'(1 << low_idx(8'(p))) : 8'h00);
            wr(2'd3, 8'h00);
            set_req(8'h00);
        end

        // R4/R10 every mask pattern with all lines requesting
        set_req(8'hFF);
        for (int m = 0; m < 256; m++) begin
            wr(2'd0, 8'(m));
            irq_chk("R4 mask irq", m != 255);
            do_ack(v);
            chk(m != 255 ? "R4 masked grant" : "R10 all masked", v,
                BASE | 8'(low_idx(~8'(m))));
            rd(2'd2, d);
            chk("R4 serv", d, m != 255 ? 8'(1 << low_idx(~8'(m))) : 8'h00);
            wr(2'd3, 8'h00);
        end
        rd(2'd1, d); chk("R4 masked pend recorded", d, 8'hFF);
        set_req(8'h00);
        wr(2'd0, 8'h00);

        // R7/R8 nesting in edge mode
        wr(2'd1, 8'h00);
        set_req(8'h20); set_req(8'h00);
        do_ack(v); chk("R5 nest first", v, BASE | 8'd5);
        set_req(8'h40); set_req(8'h00);
        irq_chk("R7 lower blocked", 1'b0);
        set_req(8'h04); set_req(8'h00);
        irq_chk("R7 higher passes", 1'b1);
        do_ack(v); chk("R5 nest second", v, BASE | 8'd2);
        rd(2'd2, d); chk("R6 nested serv", d, 8'h24);
        wr(2'd3, 8'h00);
        rd(2'd2, d); chk("R8 clears most urgent", d, 8'h20);
        irq_chk("R7 still blocked", 1'b0);
        wr(2'd3, 8'h00);
        irq_chk("R7 released", 1'b1);
        do_ack(v); chk("R5 nest third", v, BASE | 8'd6);
        wr(2'd3, 8'h00);
        rd(2'd2, d); chk("R8 final", d, 8'h00);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule